// File: doc/BRIEF.md
# Flash power mode controller

This block follows the power state of a serial flash die and tells the rest of the command logic whether it may act. It watches the active-low chip select, a per-bit strobe and the first decoded opcode of each frame from the serial front end, and the busy flag of the internal write, program and erase engine. From these it keeps one of four modes (active, standby, deep sleep, waking) and drives an enable that gates the rest of the command decoder.

Going to standby is put off while an internal cycle is still running. Deep sleep is entered only by a clean one-byte sleep frame received while idle, and once asleep the block filters out every frame except the wake opcode. A wake frame starts a fixed, parameterised recovery interval before normal operation resumes. Any wake-opcode frame long enough to carry three dummy bytes after the opcode presents a constant identification byte to the output shifter.

Top module: `flash_pm_ctrl`

## Requirements
- R1: While `cs_n` is low and the mode is neither deep sleep nor waking, `mode_o` reads ACTIVE (2'b00) from the next clock on, and `instr_en` is 1.
- R2: While `cs_n` is high and the mode is active or standby, `mode_o` is ACTIVE while `busy` is 1 and becomes STANDBY (2'b01) one clock after `busy` is 0.
- R3: A frame whose first opcode is 8'hB9 and that ends, by `cs_n` rising, with exactly 8 bit strobes counted puts `mode_o` at DEEP (2'b10) one clock after the rising edge. With 7 or 9 strobes, or any other opcode, the mode does not become DEEP.
- R4: A sleep frame that ends while `busy` is 1 is rejected and the mode stays ACTIVE.
- R5: In DEEP, `instr_en` is 0 and every frame other than the wake opcode leaves the mode at DEEP.
- R6: A frame with first opcode 8'hAB and at least 8 strobes that ends in DEEP moves the mode to WAKE (2'b11) for exactly WAKE_CYCLES clocks with `instr_en` at 0. After that the mode becomes STANDBY if `cs_n` is high and `busy` is 0.
- R7: In a frame with first opcode 8'hAB, outside WAKE, `sig_valid` is 1 and `sig_byte` equals SIG_BYTE from the clock after the 32nd strobe until `cs_n` rises. At all other times `sig_valid` is 0 and `sig_byte` is 8'h00.
- R8: After reset, `mode_o` is STANDBY, `instr_en` is 1 and `sig_valid` is 0.
- R9: Only the first `op_valid` in a frame sets the decoded opcode. Later opcode strobes in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| bit_tick | input | 1 | One-clock pulse per serial bit received |
| op_valid | input | 1 | Opcode byte strobe from the front end |
| op_code | input | 8 | Decoded opcode, valid with op_valid |
| busy | input | 1 | Internal write, program or erase cycle running |
| mode_o | output | 2 | Power mode: 00 active, 01 standby, 10 deep sleep, 11 waking |
| instr_en | output | 1 | Permits the rest of the command decoder to act |
| sig_valid | output | 1 | Identification byte is being presented |
| sig_byte | output | 8 | Identification byte, 0 when not valid |

## Verification
A wrong frame count or a wrong latched opcode appears on `mode_o` one clock after the frame's rising chip select. It shows either as a sleep entry where none is due or as a missing entry, and it also shifts the edge of `sig_valid` by whole strobes within the frame. A stuck or misloaded wake counter changes the number of WAKE clocks, which the bench counts exactly. A leaking filter in deep sleep shows as an early exit to standby after the next non-wake frame.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_STANDBY = 2'd1,
    PM_DEEP    = 2'd2,
    PM_WAKE    = 2'd3
  } pm_mode_e;

  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;
  localparam int unsigned OP_BITS  = 8;
  localparam int unsigned SIG_LEAD = 32;  // opcode plus three dummy bytes

  // Mode taken when the device is not asleep or waking.
  function automatic pm_mode_e idle_mode(input logic cs_n, input logic busy);
    return (!cs_n || busy) ? PM_ACTIVE : PM_STANDBY;
  endfunction

  // True when the block may act on instructions in this mode.
  function automatic logic decode_allowed(input pm_mode_e m);
    return (m == PM_ACTIVE) || (m == PM_STANDBY);
  endfunction

endpackage

// File: rtl/fpm_frame_track.sv
module fpm_frame_track #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             bit_tick,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  output logic             cs_rise,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       op_q,
  output logic             op_seen
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n && !cs_q;

  // Bit counter saturates so a long frame never wraps back into range.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          bit_cnt <= '0;
    else if (cs_n)                       bit_cnt <= '0;
    else if (bit_tick && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      op_seen <= 1'b0;
    end else if (cs_n) begin
      op_q    <= '0;
      op_seen <= 1'b0;
    end else if (op_valid && !op_seen) begin
      op_q    <= op_code;
      op_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/fpm_wake_timer.sv
module fpm_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic running,
  output logic done
);

  localparam int unsigned TW = $clog2(WAKE_CYCLES + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(WAKE_CYCLES);
  localparam logic [TW-1:0] LAST_VAL = TW'(1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= LOAD_VAL;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign running = (cnt != '0);
  assign done    = (cnt == LAST_VAL);

endmodule

// File: rtl/flash_pm_ctrl.sv
module flash_pm_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned WAKE_CYCLES = 4,
  parameter logic [7:0]  SIG_BYTE    = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_tick,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       busy,
  output logic [1:0] mode_o,
  output logic       instr_en,
  output logic       sig_valid,
  output logic [7:0] sig_byte
);

  localparam logic [CNT_W-1:0] SLEEP_LEN = CNT_W'(OP_BITS);
  localparam logic [CNT_W-1:0] SIG_START = CNT_W'(SIG_LEAD);

  pm_mode_e         mode_q, mode_d;
  logic             cs_rise, op_seen;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       op_q;
  logic             dp_take, rel_take, wake_run, wake_done;

  fpm_frame_track #(.CNT_W(CNT_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .bit_tick (bit_tick),
    .op_valid (op_valid),
    .op_code  (op_code),
    .cs_rise  (cs_rise),
    .bit_cnt  (bit_cnt),
    .op_q     (op_q),
    .op_seen  (op_seen)
  );

  fpm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rel_take),
    .running (wake_run),
    .done    (wake_done)
  );

  // Named events for the checker.
  assign dp_take  = cs_rise && decode_allowed(mode_q) && op_seen &&
                    (op_q == OPC_SLEEP) && (bit_cnt == SLEEP_LEN) && !busy;
  assign rel_take = cs_rise && (mode_q == PM_DEEP) && op_seen && (op_q == OPC_WAKE);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_DEEP: if (rel_take)  mode_d = PM_WAKE;
      PM_WAKE: if (wake_done) mode_d = idle_mode(cs_n, busy);
      default: mode_d = dp_take ? PM_DEEP : idle_mode(cs_n, busy);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_STANDBY;
    else        mode_q <= mode_d;
  end

  assign mode_o    = mode_q;
  assign instr_en  = decode_allowed(mode_q);
  assign sig_valid = !cs_n && op_seen && (op_q == OPC_WAKE) &&
                     (bit_cnt >= SIG_START) && (mode_q != PM_WAKE);
  assign sig_byte  = sig_valid ? SIG_BYTE : 8'h00;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
  import fpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       busy,
  input logic [1:0] mode,
  input logic       sig_valid,
  input logic       dp_take,
  input logic       rel_take,
  input logic       wake_run
);

  AST_SELECT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (mode == PM_ACTIVE || mode == PM_STANDBY)) |=> (mode == PM_ACTIVE)); // R1

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode == PM_ACTIVE || mode == PM_STANDBY)) |=> (mode == PM_ACTIVE)); // R2

  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_DEEP && !dp_take) |=> (mode != PM_DEEP)); // R3

  AST_NO_SLEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode != PM_DEEP) |=> (mode != PM_DEEP)); // R4

  AST_DEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_DEEP && !rel_take) |=> (mode == PM_DEEP)); // R5

  AST_RELEASE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_take |=> (mode == PM_WAKE)); // R6

  AST_WAKE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_WAKE) |-> wake_run); // R6

  AST_SIG_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> !cs_n); // R7

endmodule

bind flash_pm_ctrl fpm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .busy      (busy),
  .mode      (mode_o),
  .sig_valid (sig_valid),
  .dp_take   (dp_take),
  .rel_take  (rel_take),
  .wake_run  (wake_run)
);

// File: tb/sim_flash_pm_ctrl.sv
`timescale 1ns/1ps
module sim_flash_pm_ctrl;

  localparam int WAKE_N = 4;
  localparam logic [7:0] SIG = 8'h13;
  localparam logic [1:0] M_ACT = 2'd0, M_STB = 2'd1, M_DEEP = 2'd2, M_WAKE = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, bit_tick = 1'b0, op_valid = 1'b0, busy = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic [1:0] mode_o;
  logic instr_en, sig_valid;
  logic [7:0] sig_byte;

  int checks = 0, fails = 0;
  logic [1:0] exp_mode;

  always #2 clk = ~clk;

  flash_pm_ctrl #(.CNT_W(6), .WAKE_CYCLES(WAKE_N), .SIG_BYTE(SIG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_tick(bit_tick), .op_valid(op_valid),
    .op_code(op_code), .busy(busy), .mode_o(mode_o), .instr_en(instr_en),
    .sig_valid(sig_valid), .sig_byte(sig_byte)
  );

  function automatic logic en_of(input logic [1:0] m);
    return (m == M_ACT) || (m == M_STB);
  endfunction

  // Mode expected one clock after the frame-ending edge of chip select.
  function automatic logic [1:0] after_frame(input logic [1:0] pre, input logic [7:0] op,
                                              input int nbits, input logic bz);
    logic [7:0] eop;
    eop = (nbits >= 8) ? op : 8'h00;
    if (pre == M_DEEP) return (eop == 8'hAB) ? M_WAKE : M_DEEP;
    if (eop == 8'hB9 && nbits == 8 && !bz) return M_DEEP;
    return bz ? M_ACT : M_STB;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_mode(input string tag);
    chk(mode_o === exp_mode, tag, mode_o, exp_mode);
    chk(instr_en === en_of(exp_mode), {tag, " instr_en"}, instr_en, en_of(exp_mode));
  endtask

  task automatic frame(input logic [7:0] op, input int nbits, input logic [7:0] op2,
                       input int at2, input logic bz, input string tag);
    logic [1:0] pre;
    logic es;
    busy = bz;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    pre = exp_mode;
    if (en_of(exp_mode)) exp_mode = M_ACT;
    chk_mode({tag, " R1 select"});
    for (int i = 0; i < nbits; i++) begin
      bit_tick = 1'b1;
      op_valid = (i == 7) || (i == at2);
      op_code  = (i == 7) ? op : op2;
      @(negedge clk);
      bit_tick = 1'b0; op_valid = 1'b0;
      es = (nbits >= 8) && (op == 8'hAB) && (i + 1 >= 32);
      chk(sig_valid === es, {tag, " R7 sig_valid"}, sig_valid, es);
      chk(sig_byte === (es ? SIG : 8'h00), {tag, " R7 sig_byte"}, sig_byte, es ? SIG : 8'h00);
      @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
    exp_mode = after_frame(pre, op, nbits, bz);
    chk_mode({tag, " frame end"});
    chk(sig_valid === 1'b0, {tag, " R7 idle"}, sig_valid, 0);
    busy = 1'b0;
    if (exp_mode == M_WAKE) begin
      for (int k = 1; k < WAKE_N; k++) begin
        @(negedge clk);
        chk_mode({tag, " R6 waking"});
      end
      @(negedge clk);
      exp_mode = M_STB;
      chk_mode({tag, " R6 wake done"});
    end else begin
      @(negedge clk);
      if (exp_mode == M_ACT) exp_mode = M_STB;
      chk_mode({tag, " R2 settle"});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    exp_mode = M_STB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_mode("R8 reset mode");
    chk(sig_valid === 1'b0, "R8 reset sig", sig_valid, 0);

    // R2: busy holds active with chip select high
    busy = 1'b1;
    repeat (3) @(negedge clk);
    exp_mode = M_ACT; chk_mode("R2 busy active");
    busy = 1'b0;
    @(negedge clk);
    exp_mode = M_STB; chk_mode("R2 standby after busy");

    frame(8'h06, 8, 8'h00, -1, 1'b0, "R1 plain");
    frame(8'hB9, 7, 8'h00, -1, 1'b0, "R3 short sleep");
    frame(8'hB9, 9, 8'h00, -1, 1'b0, "R3 long sleep");
    frame(8'hB9, 8, 8'h00, -1, 1'b1, "R4 sleep busy");
    frame(8'hAB, 36, 8'h00, -1, 1'b0, "R7 sig awake");
    frame(8'hB9, 8, 8'h00, -1, 1'b0, "R3 sleep");
    frame(8'h06, 8, 8'h00, -1, 1'b0, "R5 ignore");
    frame(8'hB9, 8, 8'h00, -1, 1'b0, "R5 ignore sleep");
    frame(8'hAB, 4, 8'h00, -1, 1'b0, "R5 short release");
    frame(8'hAB, 40, 8'h00, -1, 1'b0, "R6 release");
    frame(8'hAB, 36, 8'hB9, 16, 1'b0, "R9 second op");
    frame(8'h06, 16, 8'hB9, 12, 1'b0, "R9 no relatch");

    for (int n = 0; n < 150; n++) begin
      logic [7:0] op;
      int nb, a2;
      logic bz;
      case ($urandom_range(0, 4))
        0: op = 8'hB9;
        1: op = 8'hAB;
        2: op = 8'h06;
        3: op = 8'h05;
        default: op = 8'($urandom);
      endcase
      nb = ($urandom_range(0, 2) == 0) ? 8 : int'($urandom_range(0, 40));
      a2 = ($urandom_range(0, 3) == 0) ? int'($urandom_range(8, 30)) : -1;
      bz = ($urandom_range(0, 3) == 0);
      frame(op, nb, 8'($urandom), a2, bz, "rand");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule